// File: doc/BRIEF.md
# Compare Timer with Self-Clearing Conversion Trigger

This block is a free-running counter with a single compare channel. When the count reaches the compare point, it raises an event line. An optional auto-clear channel lowers the line again at a second programmable count. The compare point and the clear point both move forward by a programmable step each time they fire. With both channels active, the event line becomes a PWM waveform whose period and duty are fully programmable, and it keeps running without any help from software.

The event line drives an edge detector. The detector gives a one-cycle start pulse to a downstream converter, on either the rising or the falling edge of the line. The interrupt request is the event line gated by its own enable bit, so software can mask the interrupt and still use the line as a trigger. A prescaler divides the counting rate. All settings are reached through a simple write port and a combinational read port. Registers sit at word addresses 0 to 7, in the order given in the requirements.

Top module: `cmp_trig_timer`

## Requirements
- R1: After reset, the event line, the interrupt and the start pulse are all low. Every readable register reads 0, which includes the control word, the compare point, the key and the count.
- R2: Control is at address 0. Bit 0 is run, bit 1 is line enable, bit 2 is interrupt enable and bit 3 is edge select. While run is 1, the count (address 7, also writable) goes up by one every P+1 clocks, where P is the prescaler reload at address 1. P = 0 means the count goes up every clock. While run is 0, the count holds.
- R3: A compare match sets the event line high only when the line enable bit is 1. A match with the line enable bit at 0 leaves the line low.
- R4: After each match, the compare point (address 2) advances by the step value (address 3), modulo 2^CNT_W. This happens whether or not the line is enabled.
- R5: Auto-clear is active only when bits [3:0] at address 5 equal 0xA. While it is active, the line goes low on the clock after the count equals the clear point (address 4), and the clear point then advances by the step. With prescaler reload P, the line stays high for (clear − compare)·(P+1) clocks.
- R6: When auto-clear is inactive, the line stays high until software writes a word with bit 0 set to address 6. Reading address 6 returns the line in bit 0.
- R7: Edge select 0 (the reset default) fires on the falling edge of the line. Edge select 1 fires on the rising edge. The start pulse is one clock wide and appears exactly one clock after the line changes.
- R8: The interrupt equals the line gated by the interrupt enable bit. Masking the interrupt does not stop the line or the start pulses.
- R9: If the clear point is set to the compare point plus half the step, the start pulses repeat every step·(P+1) clocks, and the line is high for half of each period.
- R10: When a compare match and a clear fall on the same count, the set wins and the line ends high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for reg_addr (combinational) |
| evt_line | output | 1 | Compare event line (PWM when auto-clear is active) |
| irq | output | 1 | Interrupt request (event line gated by its enable) |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
The hardest conditions to reach from the ports are the points that advance across the counter wrap, and a compare and a clear that land on the same count. The stimulus forces both on purpose. It preloads the counter just below its maximum, with a compare point a few counts above that. It also programs the compare point and the clear point to the same value. Random runs then vary the step, the clear offset, the prescaler and the edge select. Over several periods of each run, the bench measures the spacing between start pulses, the time the line stays high, and how far each pulse lags its edge.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_PRESC = 3'd1;
  localparam logic [2:0] A_CMP   = 3'd2;
  localparam logic [2:0] A_STEP  = 3'd3;
  localparam logic [2:0] A_CLR   = 3'd4;
  localparam logic [2:0] A_KEY   = 3'd5;
  localparam logic [2:0] A_FLAG  = 3'd6;
  localparam logic [2:0] A_COUNT = 3'd7;

  localparam int CTRL_W    = 4;
  localparam int KEY_W     = 4;
  localparam int CB_RUN    = 0;
  localparam int CB_NOTIFY = 1;
  localparam int CB_IRQEN  = 2;
  localparam int CB_RISE   = 3;

  localparam logic [KEY_W-1:0] ACLR_KEY = 4'hA;
endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] reload,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;

  // ">=" keeps the divider from running past a reload lowered mid-count
  assign tick = run && (div_q >= reload);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (!run)   div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ctt_point.sv
module ctt_point #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] step,
  input  logic [W-1:0] cnt,
  input  logic         tick,
  input  logic         arm,
  output logic         hit,
  output logic [W-1:0] point
);
  function automatic logic [W-1:0] next_point(input logic [W-1:0] p, input logic [W-1:0] s);
    return p + s;  // wraps modulo 2^W
  endfunction

  logic [W-1:0] point_q;

  assign hit   = arm && tick && (cnt == point_q);
  assign point = point_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     point_q <= '0;
    else if (load)  point_q <= load_val;
    else if (hit)   point_q <= next_point(point_q, step);
  end
endmodule

// File: rtl/ctt_edge_trig.sv
module ctt_edge_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  input  logic rise_sel,
  output logic start
);
  logic line_d;
  logic rise_det;
  logic fall_det;
  logic start_q;

  assign rise_det = line & ~line_d;
  assign fall_det = ~line & line_d;
  assign start    = start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_d  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      line_d  <= line;
      start_q <= rise_sel ? rise_det : fall_det;
    end
  end
endmodule

// File: rtl/cmp_trig_timer.sv
module cmp_trig_timer
  import ctt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             evt_line,
  output logic             irq,
  output logic             conv_start
);
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + 1'b1;
  endfunction

  logic [CTRL_W-1:0] ctrl_q;
  logic [PRE_W-1:0]  presc_q;
  logic [CNT_W-1:0]  step_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [KEY_W-1:0]  key_q;
  logic              line_q;

  // named internal events, observed by the checker
  logic              run, notify_en, irq_en, rise_sel, aclr_on;
  logic              tick;
  logic              cmp_load, clr_load, flag_clr;
  logic              cmp_hit, clr_hit;
  logic [CNT_W-1:0]  cmp_point, clr_point;

  assign run       = ctrl_q[CB_RUN];
  assign notify_en = ctrl_q[CB_NOTIFY];
  assign irq_en    = ctrl_q[CB_IRQEN];
  assign rise_sel  = ctrl_q[CB_RISE];
  assign aclr_on   = (key_q == ACLR_KEY);

  assign cmp_load  = reg_we && (reg_addr == A_CMP);
  assign clr_load  = reg_we && (reg_addr == A_CLR);
  assign flag_clr  = reg_we && (reg_addr == A_FLAG) && reg_wdata[0];

  ctt_prescaler #(.PRE_W(PRE_W)) i_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .reload(presc_q), .tick(tick)
  );

  ctt_point #(.W(CNT_W)) i_cmp (
    .clk(clk), .rst_n(rst_n), .load(cmp_load), .load_val(reg_wdata),
    .step(step_q), .cnt(cnt_q), .tick(tick), .arm(run),
    .hit(cmp_hit), .point(cmp_point)
  );

  ctt_point #(.W(CNT_W)) i_clr (
    .clk(clk), .rst_n(rst_n), .load(clr_load), .load_val(reg_wdata),
    .step(step_q), .cnt(cnt_q), .tick(tick), .arm(run && aclr_on),
    .hit(clr_hit), .point(clr_point)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      step_q  <= '0;
      key_q   <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_q  <= reg_wdata[CTRL_W-1:0];
        A_PRESC: presc_q <= reg_wdata[PRE_W-1:0];
        A_STEP:  step_q  <= reg_wdata;
        A_KEY:   key_q   <= reg_wdata[KEY_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (reg_we && (reg_addr == A_COUNT))    cnt_q <= reg_wdata;
    else if (tick)                               cnt_q <= bump(cnt_q);
  end

  // set has priority over any clear source
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       line_q <= 1'b0;
    else if (cmp_hit && notify_en)    line_q <= 1'b1;
    else if (clr_hit || flag_clr)     line_q <= 1'b0;
  end

  ctt_edge_trig i_trig (
    .clk(clk), .rst_n(rst_n), .line(line_q), .rise_sel(rise_sel), .start(conv_start)
  );

  assign evt_line = line_q;
  assign irq      = line_q & irq_en;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
      A_PRESC: reg_rdata = CNT_W'(presc_q);
      A_CMP:   reg_rdata = cmp_point;
      A_STEP:  reg_rdata = step_q;
      A_CLR:   reg_rdata = clr_point;
      A_KEY:   reg_rdata = CNT_W'(key_q);
      A_FLAG:  reg_rdata = CNT_W'(line_q);
      default: reg_rdata = cnt_q;
    endcase
  end
endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         evt_line,
  input logic         irq,
  input logic         conv_start,
  input logic         rise_sel,
  input logic         notify_en,
  input logic         cmp_hit,
  input logic         clr_hit,
  input logic         flag_clr,
  input logic         cmp_load,
  input logic [W-1:0] cmp_point,
  input logic [W-1:0] step
);
  assert_rise_from_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_line) |-> $past(cmp_hit && notify_en));

  assert_cmp_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && !cmp_load) |=> (cmp_point == W'($past(cmp_point) + $past(step))));

  assert_fall_from_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evt_line) |-> $past(clr_hit || flag_clr));

  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  assert_rise_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_sel && $rose(evt_line)) |=> conv_start);

  assert_fall_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_sel && $fell(evt_line)) |=> conv_start);

  assert_irq_needs_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> evt_line);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_hit && notify_en) |=> evt_line);
endmodule

bind cmp_trig_timer ctt_checker #(.W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .evt_line(evt_line), .irq(irq), .conv_start(conv_start),
  .rise_sel(rise_sel), .notify_en(notify_en), .cmp_hit(cmp_hit), .clr_hit(clr_hit),
  .flag_clr(flag_clr), .cmp_load(cmp_load), .cmp_point(cmp_point), .step(step_q)
);

// File: tb/test_cmp_trig_timer.sv
`timescale 1ns/1ps
module test_cmp_trig_timer;
  localparam int W = 16;
  localparam logic [2:0] A_CTRL = 0, A_PRESC = 1, A_CMP = 2, A_STEP = 3,
                         A_CLR = 4, A_KEY = 5, A_FLAG = 6, A_COUNT = 7;
  localparam int RUN = 1, NOTIFY = 2, IRQEN = 4, RISE = 8;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         reg_we = 0;
  logic [2:0]   reg_addr = 0;
  logic [W-1:0] reg_wdata = 0;
  logic [W-1:0] reg_rdata;
  logic         evt_line, irq, conv_start;

  always #2.5 clk = ~clk;

  cmp_trig_timer #(.CNT_W(W), .PRE_W(8)) i_cmp_trig_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_line(evt_line), .irq(irq), .conv_start(conv_start)
  );

  int checks = 0, failures = 0;
  int cyc = 0, rise_cyc = 0, fall_cyc = 0, last_hi = 0;
  int trig_n = 0, t_prev = 0, t_last = 0;
  logic prev_line = 0;
  logic rsel_tb = 0;

  function automatic int exp_count(int m, int p); return m / (p + 1); endfunction
  function automatic int exp_period(int s, int p); return s * (p + 1); endfunction
  function automatic int exp_high(int d, int p); return d * (p + 1); endfunction
  function automatic int exp_adv(int pt, int s); return (pt + s) % 65536; endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = W'(d);
    if (a == A_CTRL) rsel_tb = ((d & RISE) != 0);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic prep();
    wr(A_CTRL, 0);
    wr(A_FLAG, 1);
    wr(A_COUNT, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor: edge timing of the start pulse, high time and pulse spacing
  always @(negedge clk) begin
    if (rst_n) begin
      if (evt_line && !prev_line) rise_cyc = cyc;
      if (!evt_line && prev_line) begin
        fall_cyc = cyc;
        last_hi  = cyc - rise_cyc;
      end
      if (conv_start) begin
        chk("R7", cyc - (rsel_tb ? rise_cyc : fall_cyc), 1, "start lag after selected edge");
        t_prev = t_last;
        t_last = cyc;
        trig_n++;
      end
      prev_line = evt_line;
    end
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic pwm_run(input int s, input int d, input int p, input int rs, input string req);
    int c;
    c = 3 + int'($urandom % 10);
    prep();
    wr(A_PRESC, p); wr(A_STEP, s); wr(A_CMP, c); wr(A_CLR, c + d); wr(A_KEY, 'hA);
    repeat (3) @(negedge clk);
    trig_n = 0;
    wr(A_CTRL, RUN | NOTIFY | (rs != 0 ? RISE : 0));   // interrupt masked (R8)
    while (trig_n < 3) @(negedge clk);
    chk(req, t_last - t_prev, exp_period(s, p), "start pulse period");
    chk("R5", last_hi, exp_high(d, p), "line high time");
    chk("R8", int'(irq), 0, "masked irq while pulses run");
  endtask

  initial begin
    int v, v2;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", int'(evt_line), 0, "line after reset");
    chk("R1", int'(irq), 0, "irq after reset");
    chk("R1", int'(conv_start), 0, "start after reset");
    rd(A_CTRL, v);  chk("R1", v, 0, "ctrl after reset");
    rd(A_CMP, v);   chk("R1", v, 0, "compare after reset");
    rd(A_KEY, v);   chk("R1", v, 0, "key after reset");
    rd(A_COUNT, v); chk("R1", v, 0, "count after reset");

    // R2 counting with prescaler
    prep(); wr(A_PRESC, 2); wr(A_CTRL, RUN);
    wait_cyc(30);
    rd(A_COUNT, v); chk("R2", v, exp_count(30, 2), "count with divide by 3");
    prep(); wr(A_PRESC, 0); wr(A_CTRL, RUN);
    wait_cyc(30);
    rd(A_COUNT, v); chk("R2", v, exp_count(30, 0), "count with reload 0");
    wr(A_CTRL, 0);
    rd(A_COUNT, v); wait_cyc(10); rd(A_COUNT, v2);
    chk("R2", v2, v, "count holds when stopped");

    // R3 / R4 match with line disabled
    prep(); wr(A_STEP, 100); wr(A_CMP, 5); wr(A_KEY, 0); wr(A_CTRL, RUN);
    wait_cyc(20);
    chk("R3", int'(evt_line), 0, "line stays low with line enable off");
    rd(A_CMP, v); chk("R4", v, exp_adv(5, 100), "compare advanced by step");

    // R4 wrap
    prep(); wr(A_COUNT, 'hFFF0); wr(A_STEP, 32); wr(A_CMP, 'hFFF4); wr(A_CTRL, RUN);
    wait_cyc(10);
    rd(A_CMP, v); chk("R4", v, exp_adv('hFFF4, 32), "compare wraps");

    // R3 / R6 no auto-clear with wrong key
    prep(); wr(A_STEP, 100); wr(A_CMP, 5); wr(A_CLR, 8); wr(A_KEY, 5);
    wr(A_CTRL, RUN | NOTIFY);
    wait_cyc(20);
    chk("R3", int'(evt_line), 1, "line set by match");
    wait_cyc(150);
    chk("R6", int'(evt_line), 1, "line held with key not 0xA");
    rd(A_FLAG, v); chk("R6", v, 1, "flag read shows line");
    wr(A_FLAG, 1);
    chk("R6", int'(evt_line), 0, "software clear drops line");

    // R8 interrupt mask
    prep(); wr(A_STEP, 1000); wr(A_CMP, 5); wr(A_KEY, 0); wr(A_CTRL, RUN | NOTIFY);
    wait_cyc(20);
    chk("R8", int'(evt_line), 1, "line high while masked");
    chk("R8", int'(irq), 0, "irq masked");
    wr(A_CTRL, RUN | NOTIFY | IRQEN);
    chk("R8", int'(irq), 1, "irq follows line when enabled");

    // R10 set and clear on same count
    prep(); wr(A_STEP, 1000); wr(A_CMP, 10); wr(A_CLR, 10); wr(A_KEY, 'hA);
    wr(A_CTRL, RUN | NOTIFY);
    wait_cyc(20);
    chk("R10", int'(evt_line), 1, "set wins over clear");

    // R9 directed half duty, both edges
    pwm_run(40, 20, 0, 0, "R9");
    pwm_run(40, 20, 0, 1, "R9");
    chk("R9", last_hi, 20, "half duty high time");

    // random PWM shapes
    for (int i = 0; i < 8; i++) begin
      int s, d, p, rs;
      s  = 4 + int'($urandom % 60);
      d  = 1 + int'($urandom % (s - 1));
      p  = int'($urandom % 4);
      rs = int'($urandom % 2);
      pwm_run(s, d, p, rs, "R9");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule